// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-line general-purpose I/O port on a single-cycle memory-mapped bus with a 4 KB window. Software reads and writes pin data through a 256-word data aperture. The word address of the access selects which pins take part. Byte-address bits [9:2] form a per-pin mask, so one write can set or clear any subset of pins and leave the rest untouched, with no read-modify-write sequence.

A direction word chooses, for each pin, whether the port drives it. The block outputs the pin value vector and the output-enable vector. Input levels go through a two-stage synchroniser before software can read them. A data read returns the driven value for output pins and the synchronised level for input pins, and only in the bit positions that the address mask selects.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset, pin_out is 0x00, pin_oe is 0x00 and the direction word reads 0x00, so every pin is an input.
- R2: A write whose address has bits [11:10] = 0 is a data write. For each pin n, the output register bit n takes bus_wdata bit n when address bit n+2 is 1. When that address bit is 0, output register bit n keeps its value.
- R3: A data read returns 0 in every bit n whose address bit n+2 is 0, and 0 in bits [31:8].
- R4: The direction word sits at byte address 0x400. Bit n = 1 makes pin n an output and bit n = 0 makes it an input. pin_oe always equals this word, and a read of 0x400 returns it in bits [7:0].
- R5: In a masked data read, bit n carries the output register bit for output pins and the synchronised input bit for input pins.
- R6: A change on pin_in becomes visible to data reads after two rising clock edges, and not after one.
- R7: A write to any address other than the data aperture and 0x400 changes neither pin_out nor pin_oe. A read from such an address returns 0.
- R8: While bus_valid is low, neither pin_out nor pin_oe changes, and bus_rdata is 0.
- R9: Address bits [1:0] have no effect on decode. Read data is combinational in the cycle of the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access strobe for this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Driven pin values |
| pin_oe | output | 8 | Per-pin output enable |

## Verification
The bench writes through all 256 masks with differing data and compares each result with a model computed in the bench. A design that ignored the mask, or shifted it by one bit, would corrupt pins that are meant to keep their value. All 256 read masks are then swept with a mixed direction word. A wrong source select would return the output register for input pins, or the reverse, and a missing read mask would leak bits that are meant to read as zero. The bench also checks a read one edge after an input changes, which catches a synchroniser that is too short. Writes to unmapped offsets and idle cycles must leave both vectors unchanged.

// File: rtl/gpio_mask_port.sv
module gpio_mask_port #(
  parameter int NPIN   = 8,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 12'h400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe
);
  localparam int MLO = 2;
  localparam int MHI = MLO + NPIN - 1;

  logic [NPIN-1:0] out_q, dir_q, sync1, sync2, mask, rd_src;
  logic hit_data, hit_dir;

  assign mask     = bus_addr[MHI:MLO];
  assign hit_data = bus_valid && (bus_addr[ADDR_W-1:MHI+1] == '0);
  assign hit_dir  = bus_valid && (bus_addr[ADDR_W-1:MLO] == DIR_ADDR[ADDR_W-1:MLO]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) out_q <= '0;
    else if (hit_data && bus_write) out_q <= (out_q & ~mask) | (bus_wdata[NPIN-1:0] & mask);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dir_q <= '0;
    else if (hit_dir && bus_write) dir_q <= bus_wdata[NPIN-1:0];

  assign rd_src = (dir_q & out_q) | (~dir_q & sync2);

  always_comb begin
    bus_rdata = '0;
    if (hit_data && !bus_write) bus_rdata[NPIN-1:0] = rd_src & mask;
    else if (hit_dir && !bus_write) bus_rdata[NPIN-1:0] = dir_q;
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  // R2
  mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr[ADDR_W-1:MHI+1] == '0) |=>
      (((pin_out ^ $past(pin_out)) & ~$past(bus_addr[MHI:MLO])) == '0));

  // R3
  rd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr[ADDR_W-1:MHI+1] == '0) |->
      ((bus_rdata & ~{{(DATA_W-NPIN){1'b0}}, bus_addr[MHI:MLO]}) == '0));

  // R7
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr[ADDR_W-1:MHI+1] != '0 &&
     bus_addr[ADDR_W-1:MLO] != DIR_ADDR[ADDR_W-1:MLO]) |=>
      ($stable(pin_out) && $stable(pin_oe)));

  // R8
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> ($stable(pin_out) && $stable(pin_oe)));

  // R8
  idle_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> (bus_rdata == '0));
endmodule

// File: tb/sim_gpio_mask_port.sv
module sim_gpio_mask_port;
  logic clk = 0, rst_n = 0, valid = 0, wr = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [7:0] pin_in = '0, pin_out, pin_oe;
  int checks = 0, errs = 0;
  logic [7:0] model;

  always #5 clk = ~clk;

  gpio_mask_port u0 (.clk(clk), .rst_n(rst_n), .bus_valid(valid), .bus_write(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwrite(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    valid = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    valid = 0; wr = 0; addr = '0; wdata = '0;
  endtask

  task automatic bread(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    valid = 1; wr = 0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    valid = 0; addr = '0;
  endtask

  initial begin
    #1_000_000;
    errs++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [7:0] dirv, exp8;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 pin_out", {24'b0, pin_out}, 0);
    chk("R1 pin_oe", {24'b0, pin_oe}, 0);
    rst_n = 1;
    bread(12'h400, r);
    chk("R1 dir read", r, 0);

    // R2 exhaustive mask sweep
    model = 8'h00;
    for (int m = 0; m < 256; m++) begin
      logic [7:0] d;
      d = 8'(m * 37 + 11);
      bwrite(12'(m << 2), {24'hABCDEF, d});
      model = (model & ~8'(m)) | (d & 8'(m));
      chk("R2 masked write", {24'b0, pin_out}, {24'b0, model});
    end

    // R9 low address bits ignored
    bwrite(12'h3FF, 32'h0000_0055);
    model = 8'h55;
    chk("R9 addr[1:0] ignored", {24'b0, pin_out}, {24'b0, model});

    // R4 direction
    dirv = 8'hA5;
    bwrite(12'h401, {24'hFFFFFF, dirv});
    chk("R4 pin_oe", {24'b0, pin_oe}, {24'b0, dirv});
    bread(12'h400, r);
    chk("R4 dir read", r, {24'b0, dirv});

    // R5/R3 read sweep
    pin_in = 8'h3C;
    repeat (3) @(negedge clk);
    for (int m = 0; m < 256; m++) begin
      bread(12'(m << 2), r);
      exp8 = ((dirv & model) | (~dirv & 8'h3C)) & 8'(m);
      chk("R5/R3 masked read", r, {24'b0, exp8});
    end

    // R6 synchroniser latency (all inputs)
    bwrite(12'h400, 32'h0);
    pin_in = 8'h3C;
    repeat (3) @(negedge clk);
    pin_in = 8'hC3;
    @(negedge clk);
    valid = 1; wr = 0; addr = 12'h3FC;
    #1 chk("R6 one edge old", rdata, 32'h3C);
    @(negedge clk);
    #1 chk("R6 two edges new", rdata, 32'hC3);
    valid = 0; addr = '0;

    // R7 unmapped
    bwrite(12'h400, 32'h0F);
    bwrite(12'h800, 32'hFF);
    bwrite(12'h404, 32'hFF);
    bwrite(12'hFFC, 32'h00);
    chk("R7 pin_out unchanged", {24'b0, pin_out}, {24'b0, model});
    chk("R7 pin_oe unchanged", {24'b0, pin_oe}, 32'h0F);
    bread(12'h41C, r);
    chk("R7 unmapped read", r, 0);
    bread(12'hC00, r);
    chk("R7 unmapped read hi", r, 0);

    // R8 idle
    @(negedge clk);
    valid = 0; wr = 1; addr = 12'h3FC; wdata = 32'h0;
    @(negedge clk);
    chk("R8 idle pin_out", {24'b0, pin_out}, {24'b0, model});
    chk("R8 idle rdata", rdata, 0);
    wr = 0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule